// File: doc/BRIEF.md
# Delayed Register Update Queue

This block holds register writes that must not take effect at once. A producer posts a write with a countdown. The countdown is measured in ticks of a separate strobe, and idle clock cycles do not count. Every queued write keeps its own countdown and retires on its own schedule. When the countdown runs out, the write is applied to a private file of sixteen 64-bit registers. A write can replace the whole 64-bit register, replace only its lower 32-bit half, or force one bit to 1 or 0. A combinational read port shows the register file to the consumer. Typical users are delayed condition flags and late-arriving results.

The pending writes sit in a ring of eight slots. The ring is written at a fill pointer and drained at a retire pointer. A write that finishes before older writes ahead of it is applied at once and marked finished. Its slot is released only when every older slot has finished too. The pending count therefore drops in steps, each time the oldest entry and any finished entries directly behind it leave together. When several writes finish on the same tick, they are applied oldest first, so the youngest one decides the final value of a shared register.

Top module: `dq_delay_queue`

## Requirements
- R1: After reset, pending is 0, empty is 1, full is 0, consist_err is 0, and every register reads 0.
- R2: A post is accepted while pending is below 8, and pending then rises by one. At pending 8, full is 1, the post is dropped, pending is unchanged, and the dropped write never reaches the register file.
- R3: A write posted with delay d from 1 to 15 is applied on the d-th tick edge after the edge that accepted it. A tick on the accepting edge itself does not count. Delay 0 acts as delay 1. Cycles without a tick are not counted. The new value appears on rd_data in the cycle after the applying edge.
- R4: enq_bit_mode=0 with enq_wide=1 replaces all 64 bits of register enq_dest with enq_value.
- R5: enq_bit_mode=0 with enq_wide=0 replaces bits 31:0 with enq_value[31:0] and leaves bits 63:32 unchanged.
- R6: enq_bit_mode=1 with enq_wide=1 sets bit enq_bit_pos (0..63) if enq_value is nonzero and clears it otherwise. All other bits are kept.
- R7: enq_bit_mode=1 with enq_wide=0 targets bit enq_bit_pos mod 32. The set or clear choice looks only at enq_value[31:0].
- R8: A younger write with a shorter delay is applied before an older one and is applied exactly once. Pending falls only on a tick, and only when the oldest entry finishes, by that entry plus every finished entry directly behind it.
- R9: Writes that finish on the same tick are applied oldest first, so the youngest one's effect stands.
- R10: consist_err is 1 exactly when the fill and retire pointers differ while pending is 0. In correct operation it stays 0.
- R11: The pointers wrap modulo 8, so fill and drain work unchanged after any number of passes around the ring.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick | input | 1 | Countdown strobe; each live entry loses one count per tick edge |
| enq_valid | input | 1 | Post a write this cycle |
| enq_dest | input | 4 | Target register index |
| enq_bit_mode | input | 1 | 1: single-bit update; 0: word update |
| enq_bit_pos | input | 6 | Bit index for single-bit update |
| enq_wide | input | 1 | 1: 64-bit update; 0: 32-bit update |
| enq_value | input | 64 | Word data, or set/clear selector in bit mode |
| enq_delay | input | 4 | Ticks until the write is applied (0 acts as 1) |
| rd_addr | input | 4 | Register file read index |
| rd_data | output | 64 | Register contents, combinational from rd_addr |
| full | output | 1 | All eight slots are occupied |
| empty | output | 1 | No slot is occupied |
| pending | output | 4 | Number of occupied slots |
| consist_err | output | 1 | Pointers disagree with a zero count |

## Verification
A post changes pending one edge after it is accepted. An applied write shows on rd_data one edge after the tick on which its countdown reaches zero, and pending drops on that same edge if the head retires. The driver pushes each expected value right after the edge where it becomes due. The monitor then compares it at the falling edge that follows, before the driver moves the inputs again. The tests check one tick before each application that the old value is still present, and they insert idle cycles between ticks to confirm that only ticks count.

// File: rtl/dq_pkg.sv
`timescale 1ns/1ps
// Shared widths and the queued-operation record for the delayed update queue.
// Assumes a 64-bit register file indexed by a 4-bit destination.
package dq_pkg;
    localparam int DQ_DATA_W = 64;
    localparam int DQ_HALF_W = DQ_DATA_W / 2;
    localparam int DQ_IDX_W  = 4;
    localparam int DQ_POS_W  = 6;
    localparam int DQ_DLY_W  = 4;

    typedef struct packed {
        logic [DQ_IDX_W-1:0]  dest;
        logic                 bit_mode;
        logic [DQ_POS_W-1:0]  pos;
        logic                 wide;
        logic [DQ_DATA_W-1:0] value;
    } dq_op_t;
endpackage

// File: rtl/dq_slot_ctl.sv
`timescale 1ns/1ps
// Ring of pending writes with per-slot countdowns. Produces a fire vector on
// tick edges and advances the retire pointer over the finished head run.
// Assumes NSLOT >= 2; the fill slot is always free when a post is accepted.
module dq_slot_ctl
    import dq_pkg::*;
#(
    parameter  int NSLOT = 8,
    localparam int PTR_W = $clog2(NSLOT),
    localparam int CNT_W = $clog2(NSLOT + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic                enq_valid,
    input  dq_op_t              enq_op,
    input  logic [DQ_DLY_W-1:0] enq_delay,
    output dq_op_t              slot_op [NSLOT],
    output logic [NSLOT-1:0]    fire,
    output logic [PTR_W-1:0]    in_ptr,
    output logic [PTR_W-1:0]    out_ptr,
    output logic [CNT_W-1:0]    count,
    output logic                full
);
    logic [DQ_DLY_W-1:0] rem_q [NSLOT];
    logic [NSLOT-1:0]    valid_q, done_q, live, done_nx, clr;
    logic [CNT_W-1:0]    adv;
    logic                accept;

    function automatic logic [PTR_W-1:0] ptr_add(input logic [PTR_W-1:0] p, input int n);
        return PTR_W'((int'(p) + n) % NSLOT);
    endfunction

    // Live slots, and the ones whose countdown expires on this tick.
    always_comb begin
        live = valid_q & ~done_q;
        for (int i = 0; i < NSLOT; i++) begin
            fire[i] = tick && live[i] && (rem_q[i] == DQ_DLY_W'(1));
        end
        done_nx = done_q | fire;
    end

    // Walk from the retire pointer over the contiguous run of finished slots.
    always_comb begin
        logic walking;
        walking = 1'b1;
        clr     = '0;
        adv     = '0;
        for (int k = 0; k < NSLOT; k++) begin
            int idx;
            idx = (int'(out_ptr) + k) % NSLOT;
            if (walking && (k < int'(count)) && done_nx[idx]) begin
                clr[idx] = 1'b1;
                adv      = adv + CNT_W'(1);
            end else begin
                walking = 1'b0;
            end
        end
    end

    assign full   = (count == CNT_W'(NSLOT));
    assign accept = enq_valid && !full;

    // Slot state, pointers and count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            done_q  <= '0;
            in_ptr  <= '0;
            out_ptr <= '0;
            count   <= '0;
            for (int i = 0; i < NSLOT; i++) begin
                rem_q[i]   <= '0;
                slot_op[i] <= '0;
            end
        end else begin
            for (int i = 0; i < NSLOT; i++) begin
                if (tick && live[i] && (rem_q[i] != DQ_DLY_W'(1))) begin
                    rem_q[i] <= rem_q[i] - DQ_DLY_W'(1);
                end
                if (clr[i]) begin
                    valid_q[i] <= 1'b0;
                    done_q[i]  <= 1'b0;
                end else begin
                    done_q[i]  <= done_nx[i];
                end
            end
            if (accept) begin
                slot_op[in_ptr] <= enq_op;
                rem_q[in_ptr]   <= (enq_delay == '0) ? DQ_DLY_W'(1) : enq_delay;
                valid_q[in_ptr] <= 1'b1;
                done_q[in_ptr]  <= 1'b0;
                in_ptr          <= ptr_add(in_ptr, 1);
            end
            out_ptr <= ptr_add(out_ptr, int'(adv));
            count   <= count + CNT_W'(accept) - adv;
        end
    end
endmodule

// File: rtl/dq_regfile.sv
`timescale 1ns/1ps
// Target register file. Applies every firing slot in age order starting at
// the retire pointer, so a younger write to the same register wins.
// Assumes fire is nonzero only for live slots.
module dq_regfile
    import dq_pkg::*;
#(
    parameter  int NSLOT = 8,
    localparam int PTR_W = $clog2(NSLOT),
    localparam int NREG  = 2 ** DQ_IDX_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  dq_op_t               slot_op [NSLOT],
    input  logic [NSLOT-1:0]     fire,
    input  logic [PTR_W-1:0]     out_ptr,
    input  logic [DQ_IDX_W-1:0]  rd_addr,
    output logic [DQ_DATA_W-1:0] rd_data
);
    logic [DQ_DATA_W-1:0] rf_q  [NREG];
    logic [DQ_DATA_W-1:0] rf_nx [NREG];

    function automatic logic [DQ_DATA_W-1:0] apply_op(input logic [DQ_DATA_W-1:0] cur,
                                                      input dq_op_t op);
        logic [DQ_DATA_W-1:0] r;
        int                   p;
        logic                 setv;
        r = cur;
        if (op.bit_mode) begin
            p    = op.wide ? int'(op.pos) : (int'(op.pos) % DQ_HALF_W);
            setv = op.wide ? (|op.value) : (|op.value[DQ_HALF_W-1:0]);
            r[p] = setv;
        end else if (op.wide) begin
            r = op.value;
        end else begin
            r[DQ_HALF_W-1:0] = op.value[DQ_HALF_W-1:0];
        end
        return r;
    endfunction

    // Next register file contents after this cycle's expiring writes.
    always_comb begin
        for (int j = 0; j < NREG; j++) rf_nx[j] = rf_q[j];
        for (int k = 0; k < NSLOT; k++) begin
            int idx;
            idx = (int'(out_ptr) + k) % NSLOT;
            if (fire[idx]) begin
                rf_nx[slot_op[idx].dest] = apply_op(rf_nx[slot_op[idx].dest], slot_op[idx]);
            end
        end
    end

    // Register storage.
    always_ff @(posedge clk) begin
        for (int j = 0; j < NREG; j++) begin
            rf_q[j] <= rst_n ? rf_nx[j] : '0;
        end
    end

    // Read port.
    assign rd_data = rf_q[rd_addr];
endmodule

// File: rtl/dq_delay_queue.sv
`timescale 1ns/1ps
// Delayed register update queue: posted writes count down on tick edges and
// are applied to an internal register file when they expire.
// Assumes tick and enq_valid are synchronous to clk.
module dq_delay_queue
    import dq_pkg::*;
#(
    parameter  int NSLOT = 8,
    localparam int PTR_W = $clog2(NSLOT),
    localparam int CNT_W = $clog2(NSLOT + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick,
    input  logic                 enq_valid,
    input  logic [DQ_IDX_W-1:0]  enq_dest,
    input  logic                 enq_bit_mode,
    input  logic [DQ_POS_W-1:0]  enq_bit_pos,
    input  logic                 enq_wide,
    input  logic [DQ_DATA_W-1:0] enq_value,
    input  logic [DQ_DLY_W-1:0]  enq_delay,
    input  logic [DQ_IDX_W-1:0]  rd_addr,
    output logic [DQ_DATA_W-1:0] rd_data,
    output logic                 full,
    output logic                 empty,
    output logic [CNT_W-1:0]     pending,
    output logic                 consist_err
);
    dq_op_t           enq_op;
    dq_op_t           slot_op [NSLOT];
    logic [NSLOT-1:0] fire_vec;
    logic [PTR_W-1:0] in_ptr, out_ptr;

    // Pack the posted write.
    always_comb begin
        enq_op.dest     = enq_dest;
        enq_op.bit_mode = enq_bit_mode;
        enq_op.pos      = enq_bit_pos;
        enq_op.wide     = enq_wide;
        enq_op.value    = enq_value;
    end

    dq_slot_ctl #(.NSLOT(NSLOT)) u_ctl (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .enq_valid(enq_valid), .enq_op(enq_op), .enq_delay(enq_delay),
        .slot_op(slot_op), .fire(fire_vec),
        .in_ptr(in_ptr), .out_ptr(out_ptr), .count(pending), .full(full)
    );

    dq_regfile #(.NSLOT(NSLOT)) u_rf (
        .clk(clk), .rst_n(rst_n), .slot_op(slot_op), .fire(fire_vec),
        .out_ptr(out_ptr), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    // Status flags.
    assign empty       = (pending == '0);
    assign consist_err = (in_ptr != out_ptr) && (pending == '0);
endmodule

// File: rtl/dq_delay_queue_chk.sv
`timescale 1ns/1ps
// Property checker for dq_delay_queue, attached through bind.
module dq_delay_queue_chk #(
    parameter  int NSLOT = 8,
    localparam int PTR_W = $clog2(NSLOT),
    localparam int CNT_W = $clog2(NSLOT + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic             enq_valid,
    input logic             full,
    input logic [CNT_W-1:0] pending,
    input logic [PTR_W-1:0] in_ptr,
    input logic [PTR_W-1:0] out_ptr,
    input logic             consist_err
);
    p_bounded_r2: assert property (@(posedge clk) disable iff (!rst_n)
        int'(pending) <= NSLOT);

    p_refuse_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !tick) |=> (pending == $past(pending)));

    p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (enq_valid && !full && !tick) |=> (pending == $past(pending) + CNT_W'(1)));

    p_retire_on_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> (pending >= $past(pending)));

    p_no_incons_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !consist_err);

    p_full_ptrs_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(pending) == NSLOT) |-> (in_ptr == out_ptr));
endmodule

bind dq_delay_queue dq_delay_queue_chk #(.NSLOT(NSLOT)) u_chk (
    .clk(clk), .rst_n(rst_n), .tick(tick), .enq_valid(enq_valid),
    .full(full), .pending(pending), .in_ptr(in_ptr), .out_ptr(out_ptr),
    .consist_err(consist_err)
);

// File: tb/dq_delay_queue_tb.sv
`timescale 1ns/1ps
module dq_delay_queue_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        enq_valid = 1'b0;
    logic [3:0]  enq_dest = '0;
    logic        enq_bit_mode = 1'b0;
    logic [5:0]  enq_bit_pos = '0;
    logic        enq_wide = 1'b0;
    logic [63:0] enq_value = '0;
    logic [3:0]  enq_delay = '0;
    logic [3:0]  rd_addr = '0;
    logic [63:0] rd_data;
    logic        full, empty, consist_err;
    logic [3:0]  pending;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    typedef struct {
        int          kind;   // 0 register, 1 pending, 2 {full,empty,consist_err}
        logic [3:0]  a;
        logic [63:0] v;
        string       tag;
    } exp_t;
    exp_t expq[$];

    always #2.5 clk = ~clk;

    dq_delay_queue u_dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .enq_valid(enq_valid),
        .enq_dest(enq_dest), .enq_bit_mode(enq_bit_mode), .enq_bit_pos(enq_bit_pos),
        .enq_wide(enq_wide), .enq_value(enq_value), .enq_delay(enq_delay),
        .rd_addr(rd_addr), .rd_data(rd_data), .full(full), .empty(empty),
        .pending(pending), .consist_err(consist_err)
    );

    task automatic exp_reg(input logic [3:0] a, input logic [63:0] v, input string tag);
        exp_t e; e.kind = 0; e.a = a; e.v = v; e.tag = tag; expq.push_back(e);
    endtask
    task automatic exp_pend(input int n, input string tag);
        exp_t e; e.kind = 1; e.a = '0; e.v = 64'(n); e.tag = tag; expq.push_back(e);
    endtask
    task automatic exp_flags(input logic f, input logic em, input logic c, input string tag);
        exp_t e; e.kind = 2; e.a = '0; e.v = {61'd0, f, em, c}; e.tag = tag; expq.push_back(e);
    endtask

    // Monitor: compares due expectations at each falling edge.
    initial begin
        forever begin
            @(negedge clk);
            while (expq.size() > 0) begin
                exp_t e;
                logic [63:0] act;
                e = expq.pop_front();
                if (e.kind == 0) begin
                    rd_addr = e.a;
                    #0.1;
                    act = rd_data;
                end else if (e.kind == 1) begin
                    act = 64'(pending);
                end else begin
                    act = {61'd0, full, empty, consist_err};
                end
                checks++;
                if (act !== e.v) begin
                    errors++;
                    $display("FAIL %s kind=%0d idx=%0d actual=%h expected=%h",
                             e.tag, e.kind, e.a, act, e.v);
                end
            end
        end
    end

    task automatic cyc(input logic t);
        tick = t;
        @(posedge clk);
        #1;
        tick = 1'b0;
        enq_valid = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) cyc(1'b1);
    endtask

    task automatic enq(input logic [3:0] d, input logic bm, input logic [5:0] p,
                       input logic w, input logic [63:0] v, input logic [3:0] dl,
                       input logic t);
        enq_dest = d; enq_bit_mode = bm; enq_bit_pos = p;
        enq_wide = w; enq_value = v; enq_delay = dl; enq_valid = 1'b1;
        cyc(t);
    endtask

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // Driver.
    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        // R1: reset state
        for (int r = 0; r < 16; r++) exp_reg(4'(r), 64'd0, "R1 reg after reset");
        exp_pend(0, "R1 pending after reset");
        exp_flags(1'b0, 1'b1, 1'b0, "R1 flags after reset");
        cyc(1'b0);

        // R4: 64-bit word with delay 2
        enq(4'd3, 1'b0, 6'd0, 1'b1, 64'hDEAD_BEEF_0123_4567, 4'd2, 1'b0);
        exp_pend(1, "R2 pending after post");
        cyc(1'b1);
        exp_reg(4'd3, 64'd0, "R3 not yet applied after tick 1");
        cyc(1'b1);
        exp_reg(4'd3, 64'hDEAD_BEEF_0123_4567, "R4 word applied on tick 2");
        exp_pend(0, "R8 pending after retire");
        cyc(1'b0);

        // R3: idle cycles do not count; delay 0 acts as 1
        enq(4'd4, 1'b0, 6'd0, 1'b1, 64'h0404, 4'd3, 1'b0);
        cyc(1'b0); cyc(1'b0);
        cyc(1'b1); cyc(1'b0); cyc(1'b1);
        exp_reg(4'd4, 64'd0, "R3 idle cycles not counted");
        cyc(1'b1);
        exp_reg(4'd4, 64'h0404, "R3 applied on third tick");
        enq(4'd5, 1'b0, 6'd0, 1'b1, 64'h0505, 4'd0, 1'b0);
        cyc(1'b1);
        exp_reg(4'd5, 64'h0505, "R3 delay 0 acts as 1");

        // R5: 32-bit word keeps upper half
        enq(4'd3, 1'b0, 6'd0, 1'b0, 64'hFFFF_FFFF_AAAA_5555, 4'd1, 1'b0);
        cyc(1'b1);
        exp_reg(4'd3, 64'hDEAD_BEEF_AAAA_5555, "R5 narrow word");

        // R6: 64-bit bit set and clear
        enq(4'd6, 1'b1, 6'd63, 1'b1, 64'h100, 4'd1, 1'b0);
        cyc(1'b1);
        exp_reg(4'd6, 64'h8000_0000_0000_0000, "R6 set bit 63");
        enq(4'd6, 1'b1, 6'd40, 1'b1, 64'h1, 4'd1, 1'b0);
        cyc(1'b1);
        exp_reg(4'd6, 64'h8000_0100_0000_0000, "R6 set bit 40");
        enq(4'd6, 1'b1, 6'd63, 1'b1, 64'h0, 4'd1, 1'b0);
        cyc(1'b1);
        exp_reg(4'd6, 64'h0000_0100_0000_0000, "R6 clear bit 63");

        // R7: 32-bit bit mode uses pos mod 32 and low value half
        enq(4'd7, 1'b0, 6'd0, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 4'd1, 1'b0);
        cyc(1'b1);
        enq(4'd7, 1'b1, 6'd37, 1'b0, 64'hFFFF_FFFF_0000_0000, 4'd1, 1'b0);
        cyc(1'b1);
        exp_reg(4'd7, 64'hFFFF_FFFF_FFFF_FFDF, "R7 narrow clear at pos 37");
        enq(4'd14, 1'b1, 6'd37, 1'b0, 64'h1, 4'd1, 1'b0);
        cyc(1'b1);
        exp_reg(4'd14, 64'h20, "R7 narrow set at pos 37");

        // R8: out-of-order finish, single application, head-gated retire
        enq(4'd8, 1'b0, 6'd0, 1'b1, 64'h1, 4'd5, 1'b0);
        enq(4'd9, 1'b0, 6'd0, 1'b1, 64'h2, 4'd1, 1'b0);
        exp_pend(2, "R2 two posted");
        cyc(1'b1);
        exp_reg(4'd9, 64'h2, "R8 younger applied first");
        exp_reg(4'd8, 64'h0, "R8 older still waiting");
        exp_pend(2, "R8 no retire behind head");
        enq(4'd9, 1'b0, 6'd0, 1'b1, 64'h3, 4'd1, 1'b0);
        exp_pend(3, "R8 third posted");
        cyc(1'b1);
        exp_reg(4'd9, 64'h3, "R8 third applied");
        ticks(2);
        exp_pend(3, "R8 pending held by head");
        exp_reg(4'd8, 64'h0, "R8 head not yet due");
        cyc(1'b1);
        exp_reg(4'd8, 64'h1, "R8 head applied");
        exp_reg(4'd9, 64'h3, "R8 finished entry not reapplied");
        exp_pend(0, "R8 head run retired");

        // R9: same-tick completions, youngest wins
        enq(4'd10, 1'b0, 6'd0, 1'b1, 64'h11, 4'd2, 1'b0);
        enq(4'd10, 1'b0, 6'd0, 1'b1, 64'h22, 4'd2, 1'b0);
        ticks(2);
        exp_reg(4'd10, 64'h22, "R9 youngest wins");

        // R2 and R11: fill all slots after wrap, refuse extra post
        for (int i = 1; i <= 8; i++) enq(4'd11, 1'b0, 6'd0, 1'b1, 64'(i), 4'd15, 1'b0);
        exp_pend(8, "R11 full after wrap");
        exp_flags(1'b1, 1'b0, 1'b0, "R2 full flag");
        enq(4'd12, 1'b0, 6'd0, 1'b1, 64'h99, 4'd1, 1'b0);
        exp_pend(8, "R2 post refused when full");
        ticks(14);
        exp_reg(4'd11, 64'h0, "R3 delay 15 not yet due");
        exp_reg(4'd12, 64'h0, "R2 refused write absent");
        cyc(1'b1);
        exp_reg(4'd11, 64'h8, "R11 all slots applied in order");
        exp_reg(4'd12, 64'h0, "R2 refused write never applied");
        exp_pend(0, "R11 drained");
        exp_flags(1'b0, 1'b1, 1'b0, "R10 flags after drain");

        // R3: a tick on the accepting edge does not count
        enq(4'd13, 1'b0, 6'd0, 1'b1, 64'hCAFE, 4'd1, 1'b1);
        exp_reg(4'd13, 64'h0, "R3 accept-edge tick ignored");
        cyc(1'b1);
        exp_reg(4'd13, 64'hCAFE, "R3 applied on next tick");
        exp_flags(1'b0, 1'b1, 1'b0, "R10 no inconsistency");

        cyc(1'b0);
        cyc(1'b0);
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule